// File: doc/BRIEF.md
# I2C Master Command Engine

This block is an I2C master that takes its orders as a stream of 16-bit command words. There are two kinds of word. A data word clocks eight bits onto SDA, most significant bit first, and then runs a ninth acknowledge clock. A control word makes the engine take the words that follow as raw SCL/SDA level steps. The host builds START, repeated START and STOP from these steps, in the same stream as the bytes.

Both bus lines are open drain. The engine only asserts an output enable to pull a line low, or releases it to the external pull-up. After releasing SCL, the engine waits until SCL actually reads high, so a target can stretch the clock.

Reading uses the same data word, with all-ones data so that SDA stays released. The bit in the word's acknowledge field is then the master's ACK or NAK. The levels sampled on SDA form a byte, which is returned on an 8-bit valid/ready stream once the word completes. If a NAK arrives on a byte not marked final, the engine halts and raises an interrupt until the host clears it.

Top module: `i2c_cmd_engine`

## Requirements
- R1: While reset is held and in the cycle after it is released, both output enables are low (lines released), `irq` is low, `rx_valid` is low and `cmd_ready` is high.
- R2: A command word holds a step count n in bits 15:10, a final flag in bit 9, a data byte in bits 8:1, and in bit 0 the acknowledge level the master offers (1 releases SDA, 0 pulls it low).
- R3: A word with n = 0 sends its eight data bits MSB first. For each bit, `sda_oe` is high exactly when that bit is 0, and it is set while SCL is low, before SCL is released.
- R4: With no clock stretching, each bit clock lasts 32 ticks: SCL is released for 16 ticks and pulled low for 16 ticks. One tick is `TICK_DIV` clock cycles.
- R5: During the ninth clock `sda_oe` equals the inverse of bit 0 of the word. SDA read high at that clock's sample point counts as a NAK.
- R6: SDA is sampled once per data clock while SCL is high. The eight samples, MSB first, are offered on `rx_data` with `rx_valid` when the word's ninth clock ends, for writes as well as reads.
- R7: After releasing SCL, the engine does not go on while `scl_in` reads low. It keeps SCL released, fetches no word and pushes no byte until SCL reads high.
- R8: A word with n > 0 makes the next n+1 words step commands, and its other bits are ignored. In each step word only bits 1:0 count: bit 1 is the SCL level and bit 0 the SDA level (1 = released). Codes 0..3 give SCL0/SDA0, SCL0/SDA1, SCL1/SDA0 and SCL1/SDA1. Each step holds for 8 ticks, and `cmd_ready` stays low meanwhile.
- R9: A NAK on a word with the final flag clear raises `irq` when the byte is pushed. From then on `cmd_ready` stays low until `irq_clear` is high for a cycle, after which `irq` drops and fetching resumes.
- R10: A NAK on a word with the final flag set raises no interrupt, and fetching continues.
- R11: While `rx_valid` is high and `rx_ready` is low, `rx_data` holds. A later byte waits inside the engine, and no further word is fetched.
- R12: `irq_clear` has no effect outside the halted state. A pulse during a word does not prevent a halt caused by that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Engine takes the offered word on this edge |
| cmd_data | input | 16 | Command word |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Consumer takes the byte |
| rx_data | output | 8 | Received byte |
| scl_in | input | 1 | Level read back from the SCL line |
| sda_in | input | 1 | Level read back from the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| irq | output | 1 | Halted on an unexpected NAK |
| irq_clear | input | 1 | Leave the halted state |

## Verification
Two things can happen on the same clock edge: the consumer taking the held byte, and the engine loading the byte it has been holding back. The bench provokes this by keeping `rx_ready` low across two back-to-back words and then raising it. It expects the second byte on `rx_data` in the cycle right after the first is taken, with no gap and no lost byte. A second overlap puts an `irq_clear` pulse inside a word that ends in a NAK with the final flag clear. The expected outcome is that the pulse is ignored and the halt still occurs.

// File: rtl/i2c_eng_pkg.sv
// Shared constants and types for the I2C command engine.
// Assumes a 16-bit command word and a 9-clock byte frame.
package i2c_eng_pkg;
    localparam int CMD_W    = 16;
    localparam int BYTE_W   = 8;
    localparam int STEP_W   = 6;
    localparam int FRAME    = BYTE_W + 1;
    localparam int TIMER_W  = 3;

    // Phase lengths in ticks; one bit clock sums to 32 with the 1-tick wait.
    localparam int T_SETUP  = 8;
    localparam int T_RISE   = 3;
    localparam int T_DLY    = 4;
    localparam int T_HOLD   = 8;
    localparam int T_FALL   = 8;
    localparam int T_STEP   = 8;

    typedef enum logic [3:0] {
        ST_FETCH, ST_STEP_FETCH, ST_STEP_HOLD, ST_SETUP, ST_RISE,
        ST_WAIT, ST_DLY, ST_HOLD, ST_FALL, ST_PUSH, ST_HALT
    } eng_state_e;

    typedef struct packed {
        logic [STEP_W-1:0] count;
        logic              last_f;
        logic [BYTE_W-1:0] data;
        logic              ack_rel;
    } cmd_word_t;
endpackage

// File: rtl/i2c_eng_tick.sv
// Tick prescaler: produces a one-cycle tick every DIV clock cycles.
// Assumes DIV >= 1; with DIV = 1 the tick is high every cycle after reset.
module i2c_eng_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    // Count cycles and fire the tick on the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else begin
            tick <= (cnt == CW'(DIV - 1));
            cnt  <= (cnt == CW'(DIV - 1)) ? '0 : cnt + CW'(1);
        end
    end
endmodule

// File: rtl/i2c_eng_rxslot.sv
// One-entry output holding register for received bytes.
// Assumes load is asserted only when free is high.
module i2c_eng_rxslot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic         free,
    output logic         valid,
    input  logic         ready,
    output logic [W-1:0] dout
);
    assign free = !valid || ready;

    // Fill on load, empty on a consumer handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            dout  <= '0;
        end else if (load) begin
            valid <= 1'b1;
            dout  <= din;
        end else if (ready) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_eng_ctrl.sv
// Sequencer: fetches command words, runs level steps and 9-clock byte
// frames, samples SDA, and halts on an unexpected NAK.
// Assumes tick pulses for one cycle; line outputs are "released" levels.
module i2c_eng_ctrl
    import i2c_eng_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [CMD_W-1:0]  cmd_data,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_rel,
    output logic              sda_rel,
    output logic              push,
    output logic [BYTE_W-1:0] push_data,
    input  logic              slot_free,
    output logic              halted,
    input  logic              irq_clear
);
    localparam int BIT_W = $clog2(FRAME + 1);

    eng_state_e        state;
    cmd_word_t         cw;
    logic [TIMER_W-1:0] tmr;
    logic [STEP_W-1:0] steps_left;
    logic [FRAME-1:0]  shreg;
    logic [BIT_W-1:0]  bit_idx;
    logic [BYTE_W-1:0] rx_sh;
    logic              nak_q;
    logic              last_q;
    logic              fin;

    assign cw        = cmd_data;
    assign fin       = tick && (tmr == '0);
    assign cmd_ready = (state == ST_FETCH) || (state == ST_STEP_FETCH);
    assign push      = (state == ST_PUSH) && slot_free;
    assign push_data = rx_sh;
    assign halted    = (state == ST_HALT);

    // Main sequencer: phase timing, line levels, sampling and fetching.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_FETCH;
            tmr        <= '0;
            steps_left <= '0;
            shreg      <= '0;
            bit_idx    <= '0;
            rx_sh      <= '0;
            nak_q      <= 1'b0;
            last_q     <= 1'b0;
            scl_rel    <= 1'b1;
            sda_rel    <= 1'b1;
        end else begin
            if (tick && tmr != '0) begin
                tmr <= tmr - TIMER_W'(1);
            end
            case (state)
                ST_FETCH: begin
                    if (cmd_valid) begin
                        if (cw.count != '0) begin
                            steps_left <= cw.count;
                            state      <= ST_STEP_FETCH;
                        end else begin
                            shreg   <= {cw.data, cw.ack_rel};
                            last_q  <= cw.last_f;
                            bit_idx <= '0;
                            sda_rel <= cw.data[BYTE_W-1];
                            tmr     <= TIMER_W'(T_SETUP - 1);
                            state   <= ST_SETUP;
                        end
                    end
                end
                ST_STEP_FETCH: begin
                    if (cmd_valid) begin
                        scl_rel <= cmd_data[1];
                        sda_rel <= cmd_data[0];
                        tmr     <= TIMER_W'(T_STEP - 1);
                        state   <= ST_STEP_HOLD;
                    end
                end
                ST_STEP_HOLD: begin
                    if (fin) begin
                        if (steps_left == '0) begin
                            state <= ST_FETCH;
                        end else begin
                            steps_left <= steps_left - STEP_W'(1);
                            state      <= ST_STEP_FETCH;
                        end
                    end
                end
                ST_SETUP: begin
                    if (fin) begin
                        scl_rel <= 1'b1;
                        tmr     <= TIMER_W'(T_RISE - 1);
                        state   <= ST_RISE;
                    end
                end
                ST_RISE: begin
                    if (fin) begin
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (tick && scl_in) begin
                        tmr   <= TIMER_W'(T_DLY - 1);
                        state <= ST_DLY;
                    end
                end
                ST_DLY: begin
                    if (fin) begin
                        if (bit_idx == BIT_W'(FRAME - 1)) begin
                            nak_q <= sda_in;
                        end else begin
                            rx_sh <= {rx_sh[BYTE_W-2:0], sda_in};
                        end
                        tmr   <= TIMER_W'(T_HOLD - 1);
                        state <= ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (fin) begin
                        scl_rel <= 1'b0;
                        tmr     <= TIMER_W'(T_FALL - 1);
                        state   <= ST_FALL;
                    end
                end
                ST_FALL: begin
                    if (fin) begin
                        if (bit_idx == BIT_W'(FRAME - 1)) begin
                            state <= ST_PUSH;
                        end else begin
                            bit_idx <= bit_idx + BIT_W'(1);
                            shreg   <= {shreg[FRAME-2:0], 1'b0};
                            sda_rel <= shreg[FRAME-2];
                            tmr     <= TIMER_W'(T_SETUP - 1);
                            state   <= ST_SETUP;
                        end
                    end
                end
                ST_PUSH: begin
                    if (slot_free) begin
                        state <= (nak_q && !last_q) ? ST_HALT : ST_FETCH;
                    end
                end
                ST_HALT: begin
                    if (irq_clear) begin
                        state <= ST_FETCH;
                    end
                end
                default: state <= ST_FETCH;
            endcase
        end
    end
endmodule

// File: rtl/i2c_cmd_engine.sv
// Top of the I2C command engine: prescaler, sequencer and result slot.
// Assumes open-drain pads: *_oe high pulls the line low, and *_in are the
// line levels read back from the pads.
module i2c_cmd_engine
    import i2c_eng_pkg::*;
#(
    parameter int TICK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [CMD_W-1:0]  cmd_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic [BYTE_W-1:0] rx_data,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              irq,
    input  logic              irq_clear
);
    logic              tick;
    logic              scl_rel;
    logic              sda_rel;
    logic              push;
    logic [BYTE_W-1:0] push_data;
    logic              slot_free;

    i2c_eng_tick #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    i2c_eng_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready),
        .cmd_data (cmd_data),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_rel  (scl_rel),
        .sda_rel  (sda_rel),
        .push     (push),
        .push_data(push_data),
        .slot_free(slot_free),
        .halted   (irq),
        .irq_clear(irq_clear)
    );

    i2c_eng_rxslot #(.W(BYTE_W)) u_slot (
        .clk  (clk),
        .rst_n(rst_n),
        .load (push),
        .din  (push_data),
        .free (slot_free),
        .valid(rx_valid),
        .ready(rx_ready),
        .dout (rx_data)
    );

    assign scl_oe = !scl_rel;
    assign sda_oe = !sda_rel;
endmodule

// File: rtl/i2c_cmd_engine_chk.sv
// Port-level checker for the I2C command engine, attached by bind.
module i2c_cmd_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_ready,
    input logic       rx_valid,
    input logic       rx_ready,
    input logic [7:0] rx_data,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       irq,
    input logic       irq_clear
);
    // R1: reset leaves both lines released and no outputs pending.
    a_r1_reset_released: assert property (@(posedge clk)
        !rst_n |=> (!scl_oe && !sda_oe && !irq && !rx_valid && cmd_ready));

    // R9: the halt persists until cleared.
    a_r9_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !irq_clear |=> irq);

    // R9: no word is taken while halted.
    a_r9_no_fetch_halted: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !cmd_ready);

    // R9: a clear leaves the halt and reopens fetching.
    a_r9_clear_resumes: assert property (@(posedge clk) disable iff (!rst_n)
        irq && irq_clear |=> !irq && cmd_ready);

    // R11: a held byte stays put under backpressure.
    a_r11_rx_stable: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));
endmodule

bind i2c_cmd_engine i2c_cmd_engine_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_ready(cmd_ready),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .rx_data  (rx_data),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .irq      (irq),
    .irq_clear(irq_clear)
);

// File: tb/i2c_cmd_engine_test.sv
module i2c_cmd_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [15:0] cmd_data = '0;
    logic        rx_valid;
    logic        rx_ready = 1'b1;
    logic [7:0]  rx_data;
    logic        scl_oe, sda_oe, irq;
    logic        irq_clear = 1'b0;
    logic        scl_line, sda_line;
    logic        tgt_scl_low = 1'b0;
    logic        tgt_sda_low;
    logic [8:0]  tgt_pat = '0;
    logic        mon_clr = 1'b0;
    logic        prev_scl = 1'b1;
    logic [8:0]  mon_bits = '0;
    int          mon_cnt = 0;
    int          tgt_idx = 0;
    int          cyc = 0;
    int          rise_t = 0, rise_prev = 0, fall_t = 0;
    int          n_chk = 0, n_bad = 0;

    always #2 clk = !clk;   // 250 MHz

    // Fields: last, data, ack level, target pull-low pattern (first clock in bit 8).
    localparam logic [18:0] VEC [8] = '{
        {1'b0, 8'hA5, 1'b1, 9'h001},
        {1'b1, 8'h3C, 1'b1, 9'h000},
        {1'b0, 8'hFF, 1'b0, 9'h14A},
        {1'b1, 8'hFF, 1'b1, 9'h078},
        {1'b0, 8'h00, 1'b1, 9'h001},
        {1'b0, 8'hFF, 1'b1, 9'h000},
        {1'b0, 8'h81, 1'b1, 9'h001},
        {1'b0, 8'h96, 1'b1, 9'h000}
    };

    assign scl_line    = !(scl_oe || tgt_scl_low);
    assign sda_line    = !(sda_oe || tgt_sda_low);
    assign tgt_sda_low = (tgt_idx < 9) ? tgt_pat[8 - tgt_idx] : 1'b0;

    i2c_cmd_engine #(.TICK_DIV(1)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_data(cmd_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_data(rx_data), .scl_in(scl_line), .sda_in(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq), .irq_clear(irq_clear)
    );

    // Bus monitor: records SDA at SCL rises, counts SCL falls for the target.
    always @(posedge clk) begin
        cyc      <= cyc + 1;
        prev_scl <= scl_line;
        if (mon_clr) begin
            mon_cnt  <= 0;
            mon_bits <= '0;
            tgt_idx  <= 0;
        end else begin
            if (scl_line && !prev_scl) begin
                mon_bits  <= {mon_bits[7:0], sda_line};
                mon_cnt   <= mon_cnt + 1;
                rise_prev <= rise_t;
                rise_t    <= cyc;
            end
            if (!scl_line && prev_scl) begin
                tgt_idx <= tgt_idx + 1;
                fall_t  <= cyc;
            end
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        if (cyc > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
            summary();
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] w);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_data  = w;
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
    endtask

    task automatic wait_rx();
        @(negedge clk);
        while (!rx_valid) @(negedge clk);
    endtask

    task automatic clear_mon();
        @(negedge clk);
        mon_clr = 1'b1;
        @(negedge clk);
        mon_clr = 1'b0;
    endtask

    task automatic do_start();
        send({6'd1, 10'd0});
        send(16'd2);
        send(16'd0);
        wait_idle();
        clear_mon();
    endtask

    task automatic do_stop();
        tgt_pat = '0;
        send({6'd2, 10'd0});
        send(16'd0);
        send(16'd2);
        send(16'd3);
        wait_idle();
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        irq_clear = 1'b1;
        @(negedge clk);
        irq_clear = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 scl_oe", scl_oe, 0);
        check("R1 sda_oe", sda_oe, 0);
        check("R1 cmd_ready", cmd_ready, 1);
        check("R1 rx_valid", rx_valid, 0);
        check("R1 irq", irq, 0);

        // Vector table: R2/R3/R5/R6 on each word, R9/R10 on the NAK outcome.
        for (int i = 0; i < 8; i++) begin
            logic       lst;
            logic [7:0] dat;
            logic       ack;
            logic [8:0] line9;
            logic       halt_exp;
            {lst, dat, ack, tgt_pat} = VEC[i];
            line9    = {dat, ack} & ~tgt_pat;
            halt_exp = line9[0] && !lst;
            do_start();
            send({6'd0, lst, dat, ack});
            wait_rx();
            check("R6 rx byte", rx_data, line9[8:1]);
            check("R3/R5 sda per clock", mon_bits, line9);
            check("R2 nine clocks", mon_cnt, 9);
            if (i == 0) begin
                check("R4 bit period", rise_t - rise_prev, 32);
                check("R4 scl high ticks", fall_t - rise_t, 16);
            end
            if (halt_exp) begin
                check("R9 irq raised", irq, 1);
                repeat (20) @(negedge clk);
                check("R9 irq held", irq, 1);
                check("R9 no fetch", cmd_ready, 0);
                pulse_clear();
                check("R9 irq cleared", irq, 0);
                check("R9 fetch resumes", cmd_ready, 1);
            end else begin
                check(line9[0] ? "R10 nak ignored" : "R9 ack no irq", irq, 0);
            end
            do_stop();
        end

        // R8: step codes, ignored bits and 8-tick hold.
        begin
            int k;
            send({6'd2, 1'b1, 8'hFF, 1'b1});
            send(16'hFFFE);
            check("R8 code2 scl", scl_oe, 0);
            check("R8 code2 sda", sda_oe, 1);
            k = 0;
            while (!cmd_ready) begin
                k++;
                @(negedge clk);
            end
            check("R8 step hold cycles", k, 8);
            send(16'hAAA9);
            check("R8 code1 scl", scl_oe, 1);
            check("R8 code1 sda", sda_oe, 0);
            send(16'h5554);
            check("R8 code0 scl", scl_oe, 1);
            check("R8 code0 sda", sda_oe, 1);
            wait_idle();
            check("R8 control word no byte", rx_valid, 0);
            do_stop();
        end

        // R7: clock stretching holds the engine.
        do_start();
        tgt_scl_low = 1'b1;
        tgt_pat     = 9'h001;
        send({6'd0, 1'b0, 8'h3C, 1'b1});
        repeat (200) @(negedge clk);
        check("R7 scl released while held", scl_oe, 0);
        check("R7 no clock seen", mon_cnt, 0);
        check("R7 no byte", rx_valid, 0);
        check("R7 no fetch", cmd_ready, 0);
        tgt_scl_low = 1'b0;
        wait_rx();
        check("R7 byte after stretch", rx_data, 8'h3C);
        check("R7 no irq", irq, 0);
        do_stop();

        // R11: backpressure, then pop and load on the same edge.
        rx_ready = 1'b0;
        do_start();
        tgt_pat = 9'h001;
        send({6'd0, 1'b0, 8'h11, 1'b1});
        send({6'd0, 1'b1, 8'h22, 1'b1});
        repeat (600) @(negedge clk);
        check("R11 first byte held", rx_data, 8'h11);
        check("R11 valid held", rx_valid, 1);
        check("R11 no fetch while full", cmd_ready, 0);
        rx_ready = 1'b1;
        @(negedge clk);
        check("R11 second byte next cycle", rx_data, 8'h22);
        check("R11 second valid", rx_valid, 1);
        check("R11 no irq", irq, 0);
        do_stop();

        // R12: clear while idle and mid-word is ignored.
        pulse_clear();
        check("R12 idle irq", irq, 0);
        check("R12 idle ready", cmd_ready, 1);
        do_start();
        tgt_pat = 9'h000;
        send({6'd0, 1'b0, 8'h5A, 1'b1});
        repeat (100) @(negedge clk);
        pulse_clear();
        wait_rx();
        check("R12 halt despite early clear", irq, 1);
        pulse_clear();
        check("R12 cleared after halt", irq, 0);
        do_stop();

        summary();
    end
endmodule